// File: doc/BRIEF.md
# Line-Granular Coherent Read Master

This block accepts one read command at a time, made of a start byte address and a byte count. It turns the command into a sequence of AXI read bursts aimed at a cache-coherent slave port. Each burst reads exactly one 32-byte cache line, starts on a line boundary and uses full-width beats. Every burst carries cache attributes that mark it as a cacheable, read-allocating access, whatever the requester intended. The bus width is a parameter of 32, 64 or 128 bits, and the beat count of each burst follows from that width.

Read data goes straight to a valid/ready output stream. The stream's ready signal also throttles the R channel. When the command ends, a one-cycle done pulse is raised. A response error seen on any beat is reported alongside that pulse. Commands that are misaligned, empty or larger than the coherent path is meant to carry are refused at once with an error pulse, and no bus traffic follows.

Top module: `clm_read_master`

## Requirements
- R1: Every burst address has bits [4:0] equal to zero. The first burst uses the command address, and each later burst of the same command uses the previous burst address plus 32.
- R2: Every burst is INCR (ar_burst = 2'b01) with ar_size equal to log2 of the bus width in bytes (2, 3 or 4 for 32, 64 or 128 bits) and ar_len equal to the beat count minus one (7, 3 or 1), so each burst carries 32 bytes.
- R3: ar_cache bit 1 and bit 2 are always 1. Bit 0 equals the BUFFERABLE parameter and bit 3 equals the WALLOC parameter, both 0 by default, giving 4'b0110. ar_prot equals the PROT parameter (default 3'b000).
- R4: A command is rejected when address bits [4:0] are nonzero, count bits [4:0] are nonzero, the count is zero, or the count exceeds MAX_BYTES (default 256). A rejected command raises err for one cycle, in the cycle after acceptance, with done low, and issues no burst.
- R5: At most one burst is outstanding. ar_valid rises only after the R beat with r_last of the previous burst has been accepted. While ar_valid is high and ar_ready is low, ar_valid and ar_addr hold.
- R6: R beats appear on the output stream in arrival order with unchanged data. r_ready follows out_ready, so a stalled stream stalls the R channel without losing or duplicating beats.
- R7: done is high for exactly one cycle, the cycle after the final r_last handshake of an accepted command. err in that same cycle is 1 if any beat of the command had r_resp other than 2'b00, and 0 otherwise. The error flag clears for the next command.
- R8: cmd_ready is high only while no command is in progress. A command is taken on a cycle with cmd_valid and cmd_ready both high.
- R9: A valid command of N bytes issues exactly N/32 bursts.
- R10: After reset, cmd_ready is 1 and ar_valid, done and err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_bytes | input | LEN_W | Transfer size in bytes |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_addr | output | ADDR_W | Burst start address |
| ar_len | output | 8 | Beats per burst minus one |
| ar_size | output | 3 | Beat size code |
| ar_burst | output | 2 | Burst type (INCR) |
| ar_cache | output | 4 | Memory attributes |
| ar_prot | output | 3 | Protection attributes |
| r_valid | input | 1 | Read beat valid |
| r_ready | output | 1 | Read beat accepted |
| r_data | input | DATA_W | Read beat data |
| r_resp | input | 2 | Read beat response |
| r_last | input | 1 | Final beat of burst |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Stream consumer ready |
| out_data | output | DATA_W | Stream beat data |
| done | output | 1 | Command complete pulse |
| err | output | 1 | Rejection or response error |

## Verification
A corrupted line counter shows up at the ports as the wrong number of address phases before done. It appears one burst too early or too late, and the beat count on the stream no longer equals the byte count divided by the beat width. A wrong address register or step appears on the next ar_valid cycle, as a misaligned address or a gap between consecutive lines. A stuck sticky error flag shows as err raised with the done pulse of a later, clean command. Rejection faults appear in the cycle after acceptance, as a missing err pulse or an address phase that should not exist.

// File: rtl/clm_pkg.sv
package clm_pkg;
    localparam int LINE_BYTES = 32;
    localparam int LINE_SHIFT = 5;
    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } clm_state_e;
endpackage

// File: rtl/clm_cmd_check.sv
module clm_cmd_check #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BYTES = 256
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  bytes_i,
    output logic              ok_o,
    output logic [LEN_W-1:0]  lines_o
);
    import clm_pkg::*;

    logic addr_aligned;
    logic size_aligned;
    logic size_nonzero;
    logic size_in_range;

    always_comb begin
        addr_aligned  = (addr_i[LINE_SHIFT-1:0] == '0);
        size_aligned  = (bytes_i[LINE_SHIFT-1:0] == '0);
        size_nonzero  = (bytes_i != '0);
        size_in_range = (bytes_i <= LEN_W'(MAX_BYTES));
        ok_o    = addr_aligned && size_aligned && size_nonzero && size_in_range;
        lines_o = bytes_i >> LINE_SHIFT;
    end
endmodule

// File: rtl/clm_ar_attr.sv
module clm_ar_attr #(
    parameter int         DATA_W     = 64,
    parameter bit         BUFFERABLE = 1'b0,
    parameter bit         WALLOC     = 1'b0,
    parameter logic [2:0] PROT       = 3'b000
) (
    output logic [7:0] len_o,
    output logic [2:0] size_o,
    output logic [1:0] burst_o,
    output logic [3:0] cache_o,
    output logic [2:0] prot_o
);
    import clm_pkg::*;

    generate
        if (DATA_W == 32) begin : g_w32
            assign len_o  = 8'd7;
            assign size_o = 3'd2;
        end else if (DATA_W == 64) begin : g_w64
            assign len_o  = 8'd3;
            assign size_o = 3'd3;
        end else begin : g_w128
            assign len_o  = 8'd1;
            assign size_o = 3'd4;
        end
    endgenerate

    // bit2 read-allocate and bit1 cacheable are forced on
    assign cache_o = {WALLOC, 1'b1, 1'b1, BUFFERABLE};
    assign burst_o = BURST_INCR;
    assign prot_o  = PROT;
endmodule

// File: rtl/clm_read_master.sv
module clm_read_master #(
    parameter int         ADDR_W     = 32,
    parameter int         DATA_W     = 64,
    parameter int         LEN_W      = 16,
    parameter int         MAX_BYTES  = 256,
    parameter bit         BUFFERABLE = 1'b0,
    parameter bit         WALLOC     = 1'b0,
    parameter logic [2:0] PROT       = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_bytes,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic [1:0]        ar_burst,
    output logic [3:0]        ar_cache,
    output logic [2:0]        ar_prot,
    input  logic              r_valid,
    output logic              r_ready,
    input  logic [DATA_W-1:0] r_data,
    input  logic [1:0]        r_resp,
    input  logic              r_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              done,
    output logic              err
);
    import clm_pkg::*;

    typedef struct packed {
        clm_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        logic              bad;
        logic              done;
        logic              err;
    } regs_t;

    regs_t q, d;

    logic             cmd_ok;
    logic [LEN_W-1:0] cmd_lines;
    logic             beat_hs;
    logic             beat_bad;

    clm_cmd_check #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .MAX_BYTES(MAX_BYTES)
    ) u_check (
        .addr_i (cmd_addr),
        .bytes_i(cmd_bytes),
        .ok_o   (cmd_ok),
        .lines_o(cmd_lines)
    );

    clm_ar_attr #(
        .DATA_W    (DATA_W),
        .BUFFERABLE(BUFFERABLE),
        .WALLOC    (WALLOC),
        .PROT      (PROT)
    ) u_attr (
        .len_o  (ar_len),
        .size_o (ar_size),
        .burst_o(ar_burst),
        .cache_o(ar_cache),
        .prot_o (ar_prot)
    );

    // R channel is a straight pass-through to the stream
    assign r_ready   = out_ready;
    assign out_valid = r_valid;
    assign out_data  = r_data;

    assign beat_hs  = r_valid && out_ready;
    assign beat_bad = (r_resp != RESP_OKAY);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_ok) begin
                        d.st   = ST_ADDR;
                        d.addr = cmd_addr;
                        d.left = cmd_lines;
                        d.bad  = 1'b0;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            ST_ADDR: begin
                if (ar_ready) begin
                    d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                if (beat_hs) begin
                    d.bad = q.bad || beat_bad;
                    if (r_last) begin
                        d.addr = q.addr + ADDR_W'(LINE_BYTES);
                        d.left = q.left - 1'b1;
                        if (q.left == LEN_W'(1)) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            d.err  = q.bad || beat_bad;
                        end else begin
                            d.st = ST_ADDR;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.addr <= '0;
            q.left <= '0;
            q.bad  <= 1'b0;
            q.done <= 1'b0;
            q.err  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.st == ST_IDLE);
    assign ar_valid  = (q.st == ST_ADDR);
    assign ar_addr   = q.addr;
    assign done      = q.done;
    assign err       = q.err;
endmodule

// File: rtl/clm_read_master_chk.sv
module clm_read_master_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter bit BUFFERABLE = 1'b0,
    parameter bit WALLOC     = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              ar_valid,
    input logic              ar_ready,
    input logic [ADDR_W-1:0] ar_addr,
    input logic [7:0]        ar_len,
    input logic [2:0]        ar_size,
    input logic [1:0]        ar_burst,
    input logic [3:0]        ar_cache,
    input logic              r_valid,
    input logic              r_ready,
    input logic              r_last,
    input logic              done,
    input logic              err
);
    localparam int BEATS = 32 / (DATA_W / 8);
    localparam int SIZE  = $clog2(DATA_W / 8);

    logic [ADDR_W-1:0] prev_addr;
    logic              have_prev;
    logic              in_flight;
    logic [7:0]        beat_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr <= '0;
            have_prev <= 1'b0;
            in_flight <= 1'b0;
            beat_cnt  <= '0;
        end else begin
            if (cmd_valid && cmd_ready) begin
                have_prev <= 1'b0;
            end else if (ar_valid && ar_ready) begin
                have_prev <= 1'b1;
                prev_addr <= ar_addr;
            end
            if (ar_valid && ar_ready) begin
                in_flight <= 1'b1;
            end else if (r_valid && r_ready && r_last) begin
                in_flight <= 1'b0;
            end
            if (r_valid && r_ready) begin
                beat_cnt <= r_last ? 8'd0 : beat_cnt + 8'd1;
            end
        end
    end

    assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (ar_addr[4:0] == 5'd0));

    assert_line_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_ready && have_prev) |-> (ar_addr == prev_addr + ADDR_W'(32)));

    assert_burst_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (ar_len == 8'(BEATS - 1) && ar_size == 3'(SIZE) && ar_burst == 2'b01));

    assert_burst_beats_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_ready && r_last) |-> (beat_cnt == 8'(BEATS - 1)));

    assert_cache_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> (ar_cache == {WALLOC, 1'b1, 1'b1, BUFFERABLE}));

    assert_reject_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !done) |-> $past(cmd_valid && cmd_ready));

    assert_ar_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr)));

    assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> !in_flight);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd_ready && !ar_valid && !in_flight));

    assert_busy_no_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ar_valid |-> !cmd_ready);
endmodule

bind clm_read_master clm_read_master_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BUFFERABLE(BUFFERABLE),
    .WALLOC    (WALLOC)
) u_chk (.*);

// File: tb/clm_read_master_test.sv
`timescale 1ns/1ps
module clm_read_master_test;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int LEN_W  = 16;
    localparam int MAXB   = 256;
    localparam int BPB    = DATA_W / 8;
    localparam int BEATS  = 32 / BPB;
    localparam logic [19:0] EXP_ATTR = {8'(BEATS - 1), 3'd3, 2'b01, 4'b0110, 3'b000};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_bytes = '0;
    logic              ar_valid;
    logic              ar_ready = 1'b0;
    logic [ADDR_W-1:0] ar_addr;
    logic [7:0]        ar_len;
    logic [2:0]        ar_size;
    logic [1:0]        ar_burst;
    logic [3:0]        ar_cache;
    logic [2:0]        ar_prot;
    logic              r_valid = 1'b0;
    logic              r_ready;
    logic [DATA_W-1:0] r_data = '0;
    logic [1:0]        r_resp = 2'b00;
    logic              r_last = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;
    logic              done;
    logic              err;

    int n_chk = 0;
    int n_bad = 0;
    int ar_delay = 0;
    int rdy_mode = 0;
    int bad_beat = -1;
    int beat_no = 0;
    bit busy = 1'b0;

    logic [ADDR_W-1:0] cap_addr[$];
    logic [19:0]       cap_attr[$];
    logic [DATA_W-1:0] got_data[$];

    always #4 clk = ~clk;

    clm_read_master uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
        .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
        .ar_cache(ar_cache), .ar_prot(ar_prot),
        .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
        .r_resp(r_resp), .r_last(r_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done), .err(err)
    );

    function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] v;
        for (int i = 0; i < DATA_W / 32; i++) v[i*32 +: 32] = a + 32'(4 * i);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // slave model on AR/R
    initial begin
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (ar_valid) begin
                repeat (ar_delay) @(negedge clk);
                cap_addr.push_back(ar_addr);
                cap_attr.push_back({ar_len, ar_size, ar_burst, ar_cache, ar_prot});
                ar_ready = 1'b1;
                @(negedge clk);
                ar_ready = 1'b0;
                busy = 1'b1;
                for (int b = 0; b <= int'(ar_len); b++) begin
                    r_valid = 1'b1;
                    r_data  = pat(cap_addr[$] + 32'(b * BPB));
                    r_last  = (b == int'(ar_len));
                    r_resp  = (beat_no == bad_beat) ? 2'b10 : 2'b00;
                    do @(posedge clk); while (!out_ready);
                    beat_no++;
                    if (b == int'(ar_len)) busy = 1'b0;
                    @(negedge clk);
                end
                r_valid = 1'b0;
                r_last  = 1'b0;
                r_resp  = 2'b00;
            end
        end
    end

    // stream consumer and handshake recorder
    initial forever begin
        @(negedge clk);
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = ~out_ready;
            default: out_ready = ($urandom % 3) != 0;
        endcase
    end

    initial forever begin
        @(posedge clk);
        if (out_valid && out_ready) got_data.push_back(out_data);
    end

    initial forever begin
        @(negedge clk);
        if (rst_n && ar_valid && busy)
            chk(1'b0, "R5", "address phase during open burst", 1, 0);
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WDOG", "run timed out", 0, 1);
        finish_up();
    end

    task automatic send_cmd(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] n);
        @(negedge clk);
        cmd_addr  = a;
        cmd_bytes = n;
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic clear_logs();
        cap_addr.delete();
        cap_attr.delete();
        got_data.delete();
        beat_no = 0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R10", "cmd_ready after reset", cmd_ready, 1);
        chk(ar_valid == 1'b0, "R10", "ar_valid after reset", ar_valid, 0);
        chk(done == 1'b0, "R10", "done after reset", done, 0);
        chk(err == 1'b0, "R10", "err after reset", err, 0);
    endtask

    task automatic test_good(input logic [ADDR_W-1:0] a, input int n, input int dly,
                             input int mode, input int badb);
        int waited;
        clear_logs();
        ar_delay = dly;
        rdy_mode = mode;
        bad_beat = badb;
        send_cmd(a, LEN_W'(n));
        chk(cmd_ready == 1'b0, "R8", "cmd_ready while busy", cmd_ready, 0);
        chk(err == 1'b0, "R4", "no reject on legal command", err, 0);
        waited = 0;
        while (!done && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        chk(done == 1'b1, "R7", "done pulse seen", done, 1);
        chk(err == (badb >= 0), "R7", "error flag with done", err, (badb >= 0));
        @(negedge clk);
        chk(done == 1'b0, "R7", "done lasts one cycle", done, 0);
        chk(cmd_ready == 1'b1, "R8", "cmd_ready after done", cmd_ready, 1);
        chk(cap_addr.size() == n / 32, "R9", "burst count", cap_addr.size(), n / 32);
        foreach (cap_addr[i]) begin
            chk(cap_addr[i] == a + 32'(32 * i), "R1", "burst address", cap_addr[i], a + 32'(32 * i));
            chk(cap_attr[i] == EXP_ATTR, "R2", "len/size/burst/cache/prot (R3)", cap_attr[i], EXP_ATTR);
        end
        chk(got_data.size() == n / BPB, "R6", "stream beat count", got_data.size(), n / BPB);
        foreach (got_data[k]) begin
            chk(got_data[k] == pat(a + 32'(k * BPB)), "R6", "stream data order",
                got_data[k], pat(a + 32'(k * BPB)));
        end
        rdy_mode = 0;
    endtask

    task automatic test_reject(input logic [ADDR_W-1:0] a, input int n);
        clear_logs();
        send_cmd(a, LEN_W'(n));
        chk(err == 1'b1 && done == 1'b0, "R4", "reject pulse", {err, done}, 2'b10);
        repeat (6) @(negedge clk);
        chk(err == 1'b0, "R4", "reject pulse ends", err, 0);
        chk(cap_addr.size() == 0, "R4", "no burst after reject", cap_addr.size(), 0);
        chk(cmd_ready == 1'b1, "R8", "idle after reject", cmd_ready, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_good(32'h0000_0100, 32, 0, 0, -1);
        test_good(32'h0000_1000, 128, 2, 1, -1);
        test_good(32'h0000_3FE0, MAXB, 1, 2, -1);
        test_reject(32'h0000_0104, 64);
        test_reject(32'h0000_0200, 48);
        test_reject(32'h0000_0200, MAXB + 32);
        test_reject(32'h0000_0200, 0);
        test_good(32'h0000_8000, 96, 0, 1, 5);
        test_good(32'h0000_9000, 64, 0, 0, -1);
        finish_up();
    end
endmodule